// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that reads and writes PHY registers over a two-wire serial link. It supports both the short frame format (5-bit register number) and the extended format (5-bit device address plus 16-bit register address). Software first loads a 32-bit data register. It then writes a 32-bit command register with its start/busy bit set. The block produces the management clock and the serial frames. When the last frame ends it clears busy, and for reads it leaves the returned 16-bit value in the low half of the data register.

An extended-format transaction is started by one command. The block sends an address frame that carries the register address from the upper half of the data register. It waits one idle clock period, then sends the read or write frame, and only then clears busy. The bidirectional data pin is split into an output, an output enable and an input, so the pad cell stays outside the block.

Top module: `mdio_master`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), both registers read zero and mdc and mdio_oe are low.
- R2: A write to the command register (reg_sel=1) while idle stores the word. The block starts a transaction only when bit 0 of the word is 1. A stored word with bit 0 clear produces no MDC edge, and busy stays 0.
- R3: Command bits 11:8 (value d) set the MDC half period to (d+1)*DIV_UNIT clk cycles, so consecutive MDC rising edges inside a frame are 2*(d+1)*DIV_UNIT cycles apart. MDC is low whenever busy is 0.
- R4: mdio_o and mdio_oe change only while MDC is low, and input bits are sampled at the MDC rising edge.
- R5: When command bit 1 is 0, exactly one 64-bit frame is sent, MSB first. It carries 32 ones, start code 01, an opcode (01 write, 10 read), PHY address = command bits 25:21, register number = command bits 20:16, a 2-bit turnaround and 16 data bits.
- R6: In a write frame (and in an extended address frame) the turnaround is driven as 10, all 64 bits are driven, and the 16 payload bits are data register bits 15:0. In the address frame the payload is bits 31:16.
- R7: In a read frame, mdio_oe is low from the first turnaround bit to the end of the frame. The 16 bits sampled afterwards, MSB first, land in data bits 15:0, and data bits 31:16 are kept.
- R8: When command bit 1 is 1, two frames are sent, both with start code 00 and the device address from command bits 20:16. The first has opcode 00 with the register address. The second, whose first rising MDC edge comes 4 to 4 plus 2 half periods after the last rising edge of the first, has opcode 01 (write) or 11 (read). 128 rising edges occur in total.
- R9: Busy (command bit 0) clears at the end of the last frame, and the other command bits keep their value. While busy is 1, writes to either register are ignored.
- R10: Command bits 3:2 equal to 11 select a read. Every other value, including 00 and 10, selects a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the data register, 1 the command register |
| reg_wdata | input | 32 | Write data |
| cmd_q | output | 32 | Command register contents, bit 0 is busy |
| data_q | output | 32 | Data register contents, read results in bits 15:0 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
Random transactions mix both frame formats, reads and writes, PHY and register fields, and divider values 0 to 3. They separate the start codes, the opcode selection and the field placement in each frame. Read values returned by the bench's PHY model differ from the written data, so a lost or shifted sample is seen in the data register. Directed cases cover the slowest divider and the opcode values 00 and 10 that must behave as writes. A command word without the start bit must not run. A set of register writes issued mid-transaction must change neither the frames nor the final register contents.

// File: rtl/mdio_pkg.sv
// Shared constants, sequencer state type and frame-word builder for the
// management-bus master. Assumes 5-bit PHY/device fields and 16-bit payloads.
package mdio_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ADDR,
        SQ_GAP,
        SQ_LAST
    } seq_state_t;

    localparam logic [1:0] ST_SHORT   = 2'b01;
    localparam logic [1:0] ST_EXT     = 2'b00;
    localparam logic [1:0] OP_EXT_ADR = 2'b00;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_SHORT_RD = 2'b10;
    localparam logic [1:0] OP_EXT_RD  = 2'b11;
    localparam logic [1:0] TA_DRIVEN  = 2'b10;

    // Assemble the 32 bits that follow the preamble, MSB sent first.
    function automatic logic [31:0] mk_frame(
        input logic [1:0]  st,
        input logic [1:0]  op,
        input logic [4:0]  pa,
        input logic [4:0]  ra,
        input logic [15:0] pl
    );
        return {st, op, pa, ra, TA_DRIVEN, pl};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
// Half-period tick generator for MDC. Emits one tick every (sel+1)*DIV_UNIT
// clk cycles while run is high; restart realigns the count to zero.
module mdio_clkgen #(
    parameter int DIV_UNIT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [3:0] sel,
    output logic       tick
);
    localparam int CW = $clog2(16 * DIV_UNIT + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Terminal count for the selected half period.
    assign lim  = CW'((32'(sel) + 32'd1) * 32'(DIV_UNIT) - 32'd1);
    assign tick = run && !restart && (cnt_q == lim);

    // Free-running half-period counter, held at zero when idle or realigned.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (!run || restart)   cnt_q <= '0;
        else if (cnt_q == lim)      cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mdio_frame.sv
// Serialises one management frame: PRE_LEN preamble ones followed by a
// 32-bit word. MDC rises and falls on alternate ticks; data changes with the
// falling half. For reads the pin is released from the turnaround on and the
// 16 payload bits are sampled on rising ticks.
module mdio_frame #(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] word,
    input  logic        is_read,
    input  logic        tick,
    input  logic        mdio_i,
    output logic        active,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rdata
);
    localparam int NB = PRE_LEN + 32;
    localparam int IW = $clog2(NB);
    localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);
    localparam logic [IW-1:0] BODY_IDX = IW'(PRE_LEN);
    localparam logic [IW-1:0] TA_IDX   = IW'(PRE_LEN + 14);
    localparam logic [IW-1:0] DAT_IDX  = IW'(PRE_LEN + 16);

    logic          act_q, mdc_q, rd_q;
    logic [IW-1:0] idx_q;
    logic [31:0]   sh_q;
    logic [15:0]   cap_q;
    logic          at_last;

    assign at_last = (idx_q == LAST_IDX);
    assign done    = act_q && tick && mdc_q && at_last;
    assign active  = act_q;
    assign mdc     = mdc_q;
    assign rdata   = cap_q;
    // Current bit: preamble ones, then the word MSB first.
    assign mdio_o  = act_q && ((idx_q < BODY_IDX) ? 1'b1 : sh_q[31]);
    // Drive everywhere except the turnaround and data of a read.
    assign mdio_oe = act_q && !(rd_q && (idx_q >= TA_IDX));

    // Bit sequencing, MDC level, shifting and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            mdc_q <= 1'b0;
            rd_q  <= 1'b0;
            idx_q <= '0;
            sh_q  <= '0;
            cap_q <= '0;
        end else if (start) begin
            act_q <= 1'b1;
            mdc_q <= 1'b0;
            rd_q  <= is_read;
            idx_q <= '0;
            sh_q  <= word;
        end else if (act_q && tick) begin
            if (!mdc_q) begin
                mdc_q <= 1'b1;
                if (rd_q && (idx_q >= DAT_IDX))
                    cap_q <= {cap_q[14:0], mdio_i};
            end else begin
                mdc_q <= 1'b0;
                if (at_last) begin
                    act_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q >= BODY_IDX)
                        sh_q <= {sh_q[30:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Register-controlled management-bus master. Holds the command and data
// registers, accepts a command only while idle, and sequences one short-format
// frame or an extended address frame, an idle MDC period and a data frame.
// Assumes software loads the data register before the command register.
module mdio_master #(
    parameter int DIV_UNIT = 1,
    parameter int PRE_LEN  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] cmd_q,
    output logic [31:0] data_q,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio_pkg::*;

    logic [31:0] cmd_r, data_r;
    seq_state_t  st_q;
    logic        fr_start_q, gap_q;
    logic        tick, fr_active, fr_done, fr_rd;
    logic [15:0] fr_rdata;
    logic [31:0] fr_word;
    logic        busy, ext, rd, wr_cmd, wr_dat;
    logic [4:0]  phy, regdev;

    assign busy   = cmd_r[0];
    assign ext    = cmd_r[1];
    assign rd     = (cmd_r[3:2] == 2'b11);
    assign phy    = cmd_r[25:21];
    assign regdev = cmd_r[20:16];
    assign wr_cmd = reg_wr && reg_sel && !busy;
    assign wr_dat = reg_wr && !reg_sel && !busy;
    assign fr_rd  = (st_q == SQ_LAST) && rd;
    assign cmd_q  = cmd_r;
    assign data_q = data_r;

    // Pick the frame word for the state about to be sent.
    always_comb begin
        if (st_q == SQ_ADDR)
            fr_word = mk_frame(ST_EXT, OP_EXT_ADR, phy, regdev, data_r[31:16]);
        else if (ext)
            fr_word = mk_frame(ST_EXT, rd ? OP_EXT_RD : OP_WRITE, phy, regdev, data_r[15:0]);
        else
            fr_word = mk_frame(ST_SHORT, rd ? OP_SHORT_RD : OP_WRITE, phy, regdev, data_r[15:0]);
    end

    // Register writes and transaction sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_r      <= '0;
            data_r     <= '0;
            st_q       <= SQ_IDLE;
            fr_start_q <= 1'b0;
            gap_q      <= 1'b0;
        end else begin
            fr_start_q <= 1'b0;
            if (wr_dat) data_r <= reg_wdata;
            case (st_q)
                SQ_IDLE: begin
                    if (wr_cmd) begin
                        cmd_r <= reg_wdata;
                        if (reg_wdata[0]) begin
                            st_q       <= reg_wdata[1] ? SQ_ADDR : SQ_LAST;
                            fr_start_q <= 1'b1;
                        end
                    end
                end
                SQ_ADDR: begin
                    if (fr_done) begin
                        st_q  <= SQ_GAP;
                        gap_q <= 1'b0;
                    end
                end
                SQ_GAP: begin
                    if (tick) begin
                        gap_q <= 1'b1;
                        if (gap_q) begin
                            st_q       <= SQ_LAST;
                            fr_start_q <= 1'b1;
                        end
                    end
                end
                SQ_LAST: begin
                    if (fr_done) begin
                        st_q     <= SQ_IDLE;
                        cmd_r[0] <= 1'b0;
                        if (rd) data_r[15:0] <= fr_rdata;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    mdio_clkgen #(.DIV_UNIT(DIV_UNIT)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (fr_active || (st_q == SQ_GAP)),
        .restart (fr_start_q),
        .sel     (cmd_r[11:8]),
        .tick    (tick)
    );

    mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (fr_start_q),
        .word    (fr_word),
        .is_read (fr_rd),
        .tick    (tick),
        .mdio_i  (mdio_i),
        .active  (fr_active),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (fr_done),
        .rdata   (fr_rdata)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Port-level protocol checks for the management-bus master, bound to the top.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_sel,
    input logic [31:0] cmd_q,
    input logic [31:0] data_q,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R3
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_q[0] |-> !mdc);

    // R2
    oe_idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_q[0] |-> !mdio_oe);

    // R4
    pin_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R9
    cmd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_q[0]) && cmd_q[0]) |-> (cmd_q[31:1] == $past(cmd_q[31:1])));

    // R9
    data_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_q[0]) && cmd_q[0]) |-> $stable(data_q));

    // R2
    busy_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_q[0]) |-> $past(reg_wr && reg_sel));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wr  (reg_wr),
    .reg_sel (reg_sel),
    .cmd_q   (cmd_q),
    .data_q  (data_q),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_master_tb.sv
// Self-checking bench: PHY model on the pins, frame capture on MDC rises,
// expected frames and register values computed from the requirements.
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] cmd_q, data_q;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Monitor state
    int   cyc = 0;
    int   rise_cnt = 0;
    logic seen_o [0:127];
    logic seen_oe[0:127];
    int   rise_t [0:127];
    logic mdc_prev = 1'b0;
    bit   cur_rd = 1'b0;
    int   cur_base = 0;
    logic [15:0] cur_rv = '0;

    always #2.5ns clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_q(cmd_q), .data_q(data_q),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Record pins at each MDC rise and present the next PHY read bit.
    always @(negedge clk) begin
        cyc++;
        if (mdc && !mdc_prev) begin
            if (rise_cnt < 128) begin
                seen_o[rise_cnt]  = mdio_o;
                seen_oe[rise_cnt] = mdio_oe;
                rise_t[rise_cnt]  = cyc;
            end
            rise_cnt++;
            begin
                int pos;
                pos = rise_cnt - cur_base;
                if (cur_rd && pos >= 48 && pos <= 63) mdio_i = cur_rv[63 - pos];
                else if (cur_rd && pos == 47)         mdio_i = 1'b0;
                else                                  mdio_i = 1'b1;
            end
        end
        mdc_prev = mdc;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input bit sel, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [63:0] exp_frame(input logic [1:0] st, input logic [1:0] op,
            input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] pl);
        return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, pl};
    endfunction

    task automatic chk_frame(input int base, input logic [63:0] ev, input bit rdf,
                             input string req);
        int bad = 0;
        int bad_oe = 0;
        for (int i = 0; i < 64; i++) begin
            logic eo;
            eo = !(rdf && i >= 46);
            if (seen_oe[base+i] !== eo) bad_oe++;
            if (eo && seen_o[base+i] !== ev[63-i]) bad++;
        end
        chk(bad == 0, req, "frame bit mismatches", bad, 0);
        chk(bad_oe == 0, "R7", "output-enable mismatches", bad_oe, 0);
    endtask

    // One transaction with expected-value checks; poke issues writes while busy.
    task automatic run_txn(input bit ext, input logic [1:0] opc, input logic [4:0] pa,
                           input logic [4:0] ra, input logic [3:0] dv,
                           input logic [31:0] dat, input logic [15:0] rv, input bit poke);
        logic [31:0] cmd;
        bit   rdx;
        int   h, to, nr;
        logic [1:0] op2;
        rdx = (opc == 2'b11);
        h = int'(dv) + 1;
        cmd = {6'd0, pa, ra, 4'd0, dv, 4'd0, opc, ext, 1'b1};
        wr_reg(1'b0, dat);
        cur_rd = rdx; cur_base = ext ? 64 : 0; cur_rv = rv;
        rise_cnt = 0; mdio_i = 1'b1;
        wr_reg(1'b1, cmd);
        if (poke) begin
            repeat (30) @(negedge clk);
            wr_reg(1'b1, ~cmd);
            wr_reg(1'b0, ~dat);
        end
        to = 0;
        while (cmd_q[0] && to < 20000) begin @(negedge clk); to++; end
        chk(to < 20000, "R9", "busy cleared before timeout", to, 0);
        nr = ext ? 128 : 64;
        chk(rise_cnt == nr, ext ? "R8" : "R5", "MDC rising edge count", rise_cnt, nr);
        if (rise_cnt == nr) begin
            if (ext) begin
                chk_frame(0, exp_frame(2'b00, 2'b00, pa, ra, dat[31:16]), 1'b0, "R8");
                op2 = rdx ? 2'b11 : 2'b01;
                chk_frame(64, exp_frame(2'b00, op2, pa, ra, dat[15:0]), rdx, "R10");
                chk((rise_t[64] - rise_t[63]) >= 4*h && (rise_t[64] - rise_t[63]) <= 4*h + 2,
                    "R8", "gap between frames", rise_t[64] - rise_t[63], 4*h + 1);
            end else begin
                op2 = rdx ? 2'b10 : 2'b01;
                chk_frame(0, exp_frame(2'b01, op2, pa, ra, dat[15:0]), rdx, "R5");
            end
            chk(rise_t[1] - rise_t[0] == 2*h, "R3", "MDC period", rise_t[1] - rise_t[0], 2*h);
        end
        if (rdx) chk(data_q == {dat[31:16], rv}, "R7", "read result", data_q, {dat[31:16], rv});
        else     chk(data_q == dat, "R6", "data after write", data_q, dat);
        chk(cmd_q == {cmd[31:1], 1'b0}, "R9", "command after completion", cmd_q, {cmd[31:1], 1'b0});
    endtask

    // Global watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(cmd_q == 0, "R1", "cmd after reset", cmd_q, 0);
        chk(data_q == 0, "R1", "data after reset", data_q, 0);
        chk(!mdc && !mdio_oe, "R1", "pins after reset", {mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 stored command without start bit does nothing
        rise_cnt = 0;
        wr_reg(1'b1, 32'h0123_0F0C);
        repeat (100) @(negedge clk);
        chk(rise_cnt == 0, "R2", "edges without start bit", rise_cnt, 0);
        chk(cmd_q == 32'h0123_0F0C, "R2", "stored command", cmd_q, 32'h0123_0F0C);

        // Directed corners
        run_txn(1'b0, 2'b01, 5'h1F, 5'h00, 4'd0, 32'hA5A5_FFFF, 16'h0, 1'b0);   // R6
        run_txn(1'b1, 2'b11, 5'h03, 5'h1E, 4'd15, 32'hBEEF_1234, 16'hC3A5, 1'b0); // R8 slow
        run_txn(1'b0, 2'b10, 5'h05, 5'h0A, 4'd1, 32'h0000_5A5A, 16'h0, 1'b0);  // R10 10 = write
        run_txn(1'b1, 2'b00, 5'h11, 5'h07, 4'd2, 32'h8001_7FFE, 16'h0, 1'b0);  // R10 00 = write
        run_txn(1'b0, 2'b11, 5'h0C, 5'h13, 4'd1, 32'hFFFF_0000, 16'h8001, 1'b1); // R9 poke
        run_txn(1'b1, 2'b01, 5'h16, 5'h09, 4'd0, 32'h1357_9BDF, 16'h0, 1'b1);  // R9 poke

        // Constrained random mix
        for (int n = 0; n < 24; n++) begin
            logic [1:0] opc;
            opc = ($urandom % 2) ? 2'b11 : 2'b01;
            run_txn(1'($urandom % 2), opc, 5'($urandom), 5'($urandom), 4'($urandom % 4),
                    $urandom, 16'($urandom), 1'b0);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule